// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the already-synchronized levels of one bank of general-purpose pins and turns pin activity into interrupt requests. Each pin can be set to trigger on a rising edge, a falling edge, either edge, a high level or a low level. A detected event sets a sticky per-pin status bit, which software clears by writing ones. A per-pin mask gates which status bits reach the single combined interrupt output.

Software drives the block through a simple write port: a valid strobe, a register select code and a data word as wide as the bank. The mask is never written directly. One select code clears mask bits and another sets them, so two drivers can change different pins without a read-modify-write. Detection goes on while a pin is masked, so an event that arrived during the masked window raises the interrupt as soon as the pin is unmasked. The mask and status registers are exposed as outputs so that they can be read back.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is held, and on the first cycle after reset, every mask bit is 1, every status bit is 0 and the interrupt output is 0. The trigger-type, polarity and any-edge registers reset to 0, so every pin starts as a low-level trigger.
- R2: A pin with trigger-type 1 and polarity 1 (any-edge 0) sets its status bit on a 0-to-1 change of its input. A 1-to-0 change does not set it.
- R3: A pin with trigger-type 1 and polarity 0 (any-edge 0) sets its status bit on a 1-to-0 change of its input. A 0-to-1 change does not set it.
- R4: A pin with trigger-type 1 and any-edge 1 sets its status bit on both changes, whatever its polarity.
- R5: A pin with trigger-type 0 sets its status bit in every cycle in which its input equals its polarity bit. The any-edge bit has no effect on such a pin.
- R6: A write with select code 3 clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R7: A write with select code 4 sets each mask bit whose data bit is 1, so writing all ones masks every pin at once.
- R8: A write with select code 5 clears each status bit whose data bit is 1. Other status bits keep their value. Status bits are sticky and change only through detection or this write.
- R9: Masking does not stop detection. A masked pin still records its events in status, and the interrupt rises on the cycle after that pin is unmasked.
- R10: The interrupt output is 1 exactly when some pin has its status bit set and its mask bit clear.
- R11: A level-triggered pin whose level is still active when its status is cleared shows its status bit set again after the clear.
- R12: When a status-clear write and a new event for the same pin happen in the same cycle, the status bit ends up set.
- R13: Select code 0 writes the trigger-type register, 1 writes polarity and 2 writes any-edge. A write takes effect on the next clock edge, and a write with any select code of 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level_i | input | NPINS | Synchronized pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select code |
| wr_data_i | input | NPINS | Write data, one bit per pin |
| mask_o | output | NPINS | Current mask, 1 means masked |
| status_o | output | NPINS | Current sticky event status |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bank is split by configuration: the lower half is set to rising edges and the upper half to falling edges. A single pin pattern then shows whether each polarity fires on its own edge only. Pins set to any-edge with opposite polarities are toggled both ways to show that polarity stops mattering in that mode. Level pins are held active across a clear, and one level pin also has any-edge set, to separate level behaviour from edge behaviour. A clear that coincides with a fresh edge, writes with partial and full masks, and writes to unused select codes cover the rules of priority and isolation.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the GPIO bank interrupt detector.
// Holds the write select codes and the decoded write strobe bundle.
package gpio_irq_pkg;

    localparam int unsigned SEL_W = 3;

    // Select codes seen on the register write port
    typedef enum logic [SEL_W-1:0] {
        SEL_TRIG_TYPE = 3'd0,
        SEL_TRIG_POL  = 3'd1,
        SEL_TRIG_ANY  = 3'd2,
        SEL_UNMASK    = 3'd3,
        SEL_MASK      = 3'd4,
        SEL_ACK       = 3'd5
    } reg_sel_e;

    // One strobe per writable target
    typedef struct packed {
        logic trig_type;
        logic trig_pol;
        logic trig_any;
        logic unmask;
        logic mask;
        logic ack;
    } wr_stb_t;

endpackage

// File: rtl/gpio_irq_wdec.sv
// Write-port decoder.
// Turns a valid strobe plus select code into one strobe per target.
// Assumes at most one write per cycle; codes 6 and 7 select nothing.
module gpio_irq_wdec
    import gpio_irq_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    output wr_stb_t          stb
);

    // Decode the select code into individual strobes
    always_comb begin
        stb           = '0;
        stb.trig_type = wr_en && (wr_sel == SEL_TRIG_TYPE);
        stb.trig_pol  = wr_en && (wr_sel == SEL_TRIG_POL);
        stb.trig_any  = wr_en && (wr_sel == SEL_TRIG_ANY);
        stb.unmask    = wr_en && (wr_sel == SEL_UNMASK);
        stb.mask      = wr_en && (wr_sel == SEL_MASK);
        stb.ack       = wr_en && (wr_sel == SEL_ACK);
    end

endmodule

// File: rtl/gpio_irq_cfg.sv
// Trigger configuration registers: type (1 edge, 0 level), polarity
// (1 rising/high, 0 falling/low) and any-edge (both edges, for edge
// pins only). A whole-word write replaces each register; all reset to 0.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_stb_t          stb,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] cfg_edge,
    output logic [NPINS-1:0] cfg_pol,
    output logic [NPINS-1:0] cfg_any
);

    // Trigger-type register
    always_ff @(posedge clk) begin
        if (!rst_n)             cfg_edge <= '0;
        else if (stb.trig_type) cfg_edge <= wr_data;
    end

    // Polarity register
    always_ff @(posedge clk) begin
        if (!rst_n)            cfg_pol <= '0;
        else if (stb.trig_pol) cfg_pol <= wr_data;
    end

    // Any-edge register
    always_ff @(posedge clk) begin
        if (!rst_n)            cfg_any <= '0;
        else if (stb.trig_any) cfg_any <= wr_data;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin event detector.
// Keeps one cycle of pin history and flags, in the current cycle, each
// pin whose configured condition holds. History resets to 0, so a pin
// that is high when reset is released looks like a rising edge.
module gpio_irq_detect #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_level,
    input  logic [NPINS-1:0] cfg_edge,
    input  logic [NPINS-1:0] cfg_pol,
    input  logic [NPINS-1:0] cfg_any,
    output logic [NPINS-1:0] event_hit
);

    logic [NPINS-1:0] level_q;

    // Remember last cycle's pin levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= pin_level;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic rise;
        logic fall;
        logic edge_hit;
        logic level_hit;

        assign rise      = pin_level[p] & ~level_q[p];
        assign fall      = ~pin_level[p] & level_q[p];
        assign edge_hit  = cfg_any[p] ? (rise | fall)
                                      : (cfg_pol[p] ? rise : fall);
        assign level_hit = ~(pin_level[p] ^ cfg_pol[p]);
        assign event_hit[p] = cfg_edge[p] ? edge_hit : level_hit;
    end

endmodule

// File: rtl/gpio_irq_state.sv
// Mask and sticky status registers.
// Mask: set/clear by separate write-one strobes, resets to all ones.
// Status: set by events, cleared by write-one; an event in the same
// cycle as its clear wins. Detection is not gated by the mask.
module gpio_irq_state
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_stb_t          stb,
    input  logic [NPINS-1:0] wr_data,
    input  logic [NPINS-1:0] event_hit,
    output logic [NPINS-1:0] mask_q,
    output logic [NPINS-1:0] status_q
);

    logic [NPINS-1:0] ack_bits;

    // Select the bits a status-clear write targets
    always_comb begin
        ack_bits = stb.ack ? wr_data : '0;
    end

    // Mask register updated through unmask/mask strobes
    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= '1;
        else if (stb.unmask) mask_q <= mask_q & ~wr_data;
        else if (stb.mask)   mask_q <= mask_q | wr_data;
    end

    // Sticky status: clear requested bits, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~ack_bits) | event_hit;
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// Top of the GPIO bank interrupt detector.
// Assumes pin levels are already synchronized to clk. Combines the
// unmasked status bits into one interrupt request.
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_level_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [NPINS-1:0] wr_data_i,
    output logic [NPINS-1:0] mask_o,
    output logic [NPINS-1:0] status_o,
    output logic             irq_o
);

    wr_stb_t          stb;
    logic [NPINS-1:0] cfg_edge;
    logic [NPINS-1:0] cfg_pol;
    logic [NPINS-1:0] cfg_any;
    logic [NPINS-1:0] event_hit;

    gpio_irq_wdec u_wdec (
        .wr_en  (wr_en_i),
        .wr_sel (wr_sel_i),
        .stb    (stb)
    );

    gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (stb),
        .wr_data  (wr_data_i),
        .cfg_edge (cfg_edge),
        .cfg_pol  (cfg_pol),
        .cfg_any  (cfg_any)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_level (pin_level_i),
        .cfg_edge  (cfg_edge),
        .cfg_pol   (cfg_pol),
        .cfg_any   (cfg_any),
        .event_hit (event_hit)
    );

    gpio_irq_state #(.NPINS(NPINS)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (stb),
        .wr_data   (wr_data_i),
        .event_hit (event_hit),
        .mask_q    (mask_o),
        .status_q  (status_o)
    );

    // Combined request: any pending event on an unmasked pin
    always_comb begin
        irq_o = |(status_o & ~mask_o);
    end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Assertion checker for gpio_irq_bank, attached by bind below.
// Rebuilds the write decode from the ports and checks register
// behaviour across clock edges.
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pin_level_i,
    input logic             wr_en_i,
    input logic [SEL_W-1:0] wr_sel_i,
    input logic [NPINS-1:0] wr_data_i,
    input logic [NPINS-1:0] mask_o,
    input logic [NPINS-1:0] status_o,
    input logic             irq_o,
    input logic [NPINS-1:0] cfg_edge,
    input logic [NPINS-1:0] cfg_pol
);

    logic seen_rst_q = 1'b0;
    logic live_q     = 1'b0;
    logic prev_rst_q = 1'b1;

    // Track reset history so past values are only used after reset
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst_q <= 1'b1;
        live_q     <= seen_rst_q && rst_n;
        prev_rst_q <= rst_n;
    end

    logic [NPINS-1:0] ack_vec;
    logic [NPINS-1:0] unmask_vec;
    logic [NPINS-1:0] mask_vec;
    logic [NPINS-1:0] lvl_active;

    always_comb begin
        ack_vec    = (wr_en_i && wr_sel_i == SEL_ACK)    ? wr_data_i : '0;
        unmask_vec = (wr_en_i && wr_sel_i == SEL_UNMASK) ? wr_data_i : '0;
        mask_vec   = (wr_en_i && wr_sel_i == SEL_MASK)   ? wr_data_i : '0;
        lvl_active = ~cfg_edge & ~(pin_level_i ^ cfg_pol);
    end

    // R1: first cycle after reset shows reset state
    a_r1_reset_state: assert property (@(posedge clk)
        (rst_n && !prev_rst_q) |-> (mask_o == '1 && status_o == '0 && !irq_o));

    // R6: unmask write clears the targeted mask bits
    a_r6_unmask: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((mask_o & $past(unmask_vec)) == '0));

    // R7: mask write sets the targeted mask bits
    a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((mask_o & $past(mask_vec)) == $past(mask_vec)));

    // R8: status bits only drop where a clear was written
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (($past(status_o) & ~$past(ack_vec) & ~status_o) == '0));

    // R11: an active level pin is set afterwards regardless of any clear
    a_r11_level_reset: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((status_o & $past(lvl_active)) == $past(lvl_active)));

    // R10: interrupt matches pending unmasked status
    a_r10_irq_combine: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(status_o & ~mask_o)));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_level_i (pin_level_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .mask_o      (mask_o),
    .status_o    (status_o),
    .irq_o       (irq_o),
    .cfg_edge    (cfg_edge),
    .cfg_pol     (cfg_pol)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
// Directed bench for gpio_irq_bank: one task per scenario.
module gpio_irq_bank_tb_top;

    localparam int unsigned NPINS = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPINS-1:0]  pin_level_i = '0;
    logic              wr_en_i = 1'b0;
    logic [2:0]        wr_sel_i = '0;
    logic [NPINS-1:0]  wr_data_i = '0;
    logic [NPINS-1:0]  mask_o;
    logic [NPINS-1:0]  status_o;
    logic              irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_bank #(.NPINS(NPINS)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_level_i (pin_level_i),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .wr_data_i   (wr_data_i),
        .mask_o      (mask_o),
        .status_o    (status_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One register write; returns at the negedge after it took effect
    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    // Change pins; returns once status reflects the change
    task automatic pins(input logic [31:0] v);
        @(negedge clk);
        pin_level_i = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 mask", mask_o, 32'hFFFF_FFFF);
        chk("R1 status", status_o, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // default config is level-low; pins low so all fire, yet masked
        chk("R9 masked status records", status_o, 32'hFFFF_FFFF);
        chk("R9 masked irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_setup();
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0000_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R8 clear all", status_o, 32'h0);
        wr(3'd3, 32'h0000_00FF);
        chk("R6 partial unmask", mask_o, 32'hFFFF_FF00);
        wr(3'd3, 32'hFFFF_FFFF);
        chk("R6 full unmask", mask_o, 32'h0);
        chk("R10 no pending", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_edges();
        pins(32'h0001_0001);
        chk("R2 rise", status_o, 32'h0000_0001);
        chk("R10 irq up", {31'b0, irq_o}, 32'h1);
        pins(32'h0);
        chk("R3 fall", status_o, 32'h0001_0001);
        wr(3'd5, 32'h0000_0001);
        chk("R8 partial clear", status_o, 32'h0001_0000);
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R10 irq down", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_any();
        wr(3'd2, 32'h0100_0100);
        pins(32'h0100_0100);
        chk("R4 both rise", status_o, 32'h0100_0100);
        wr(3'd5, 32'hFFFF_FFFF);
        pins(32'h0);
        chk("R4 both fall", status_o, 32'h0100_0100);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd2, 32'h0000_0008);
    endtask

    task automatic t_level();
        wr(3'd0, 32'hFFFF_FF00);
        chk("R13 type write quiet", status_o, 32'h0);
        pins(32'h0000_0004);
        chk("R5 level high", status_o, 32'h0000_0004);
        wr(3'd5, 32'h0000_0004);
        chk("R11 re-set while active", status_o, 32'h0000_0004);
        pins(32'h0);
        wr(3'd5, 32'h0000_0004);
        chk("R11 clears once idle", status_o, 32'h0);
        pins(32'h0000_0008);
        chk("R5 level any-edge pin high", status_o, 32'h0000_0008);
        pins(32'h0);
        wr(3'd5, 32'h0000_0008);
        chk("R5 any-edge ignored on level", status_o, 32'h0);
    endtask

    task automatic t_collide();
        @(negedge clk);
        pin_level_i = 32'h0000_0200;
        wr_en_i = 1'b1; wr_sel_i = 3'd5; wr_data_i = 32'h0000_0200;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
        chk("R12 event beats clear", status_o, 32'h0000_0200);
        wr(3'd5, 32'h0000_0200);
        pins(32'h0);
        chk("R12 then clear", status_o, 32'h0);
    endtask

    task automatic t_mask();
        wr(3'd4, 32'h0000_0010);
        chk("R7 mask one", mask_o, 32'h0000_0010);
        pins(32'h0000_0010);
        chk("R9 masked event kept", status_o, 32'h0000_0010);
        chk("R9 masked no irq", {31'b0, irq_o}, 32'h0);
        wr(3'd3, 32'h0000_0010);
        chk("R9 irq on unmask", {31'b0, irq_o}, 32'h1);
        wr(3'd4, 32'hFFFF_FFFF);
        chk("R7 mask all", mask_o, 32'hFFFF_FFFF);
        chk("R7 irq off", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_unused();
        wr(3'd7, 32'hFFFF_FFFF);
        chk("R13 code7 mask", mask_o, 32'hFFFF_FFFF);
        chk("R13 code7 status", status_o, 32'h0000_0010);
        wr(3'd6, 32'h0000_0000);
        chk("R13 code6 mask", mask_o, 32'hFFFF_FFFF);
        pins(32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R13 final clear", status_o, 32'h0);
    endtask

    initial begin
        t_reset();
        t_setup();
        t_edges();
        t_any();
        t_level();
        t_collide();
        t_mask();
        t_unused();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule